// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns 32 general-purpose input pins into interrupt sources. Each pin is first brought into the clock domain by a synchroniser. The pin is then judged either on its level or on its edges. The result of that judgement is captured in a per-pin status bit. A single combined interrupt line is raised whenever a pin that has been enabled shows pending status.

Software reaches every control through a 16-bit register bus. Each control is split into two 16-bit halves. The low half serves pins 0 to 15. The high half serves pins 16 to 31, with pin n at bit n-16. For each pin, software chooses:
- the trigger kind, level or edge;
- the active polarity;
- whether status is latched until cleared or follows the detected condition;
- which edges count.

Status is cleared by writing ones to it. Status capture goes on whether or not the pin is enabled; only the combined output is masked.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0 and irq_o is 0.
- R2: The control registers sit at these byte addresses (low, high): enable 0x0C/0x0E, trigger kind 0x10/0x12, polarity 0x14/0x16, latch 0x18/0x1A, falling select 0x20/0x22, rising select 0x24/0x26. Each reads back its last written value. A write takes effect at the clock edge that samples wr_en_i. Read data appears on rdata_o after the edge that samples rd_en_i and holds until the next read. Unmapped addresses read 0.
- R3: With trigger kind 0 (level) and latch 0, a pin's status bit equals its polarity-adjusted input. It takes up the new value at the third clock edge after the pin changes.
- R4: Polarity bit 1 makes a pin active high; polarity bit 0 makes it active low.
- R5: With trigger kind 1 (edge), the rising select detects 0-to-1 transitions and the falling select detects 1-to-0 transitions. With both selects set, both transitions are detected. With latch 0, a detected edge sets status for exactly one cycle.
- R6: Status sits at 0x08 (pins 0-15) and 0x0A (pins 16-31). Writing a 1 to a bit clears that pin's latched status; bits written 0 leave status unchanged.
- R7: With latch 1, a detected condition sets status and status stays set until cleared per R6.
- R8: irq_o is 1 exactly when some pin has both status and enable set. Status is captured while the pin is disabled, so setting the enable bit raises irq_o at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Asynchronous pin inputs |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| rd_en_i | input | 1 | Single-cycle register read strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
A pin change reaches status, and therefore irq_o, at the third rising edge after it is driven. That delay is made up of two synchroniser stages and the status flop. The bench drives pins on a falling edge and checks irq_o at the falling edge after the second rising edge, expecting the old value. It checks again after the third rising edge, expecting the new value, and for edge pass-through once more after the fourth, when the one-cycle pulse must be gone. Register writes are visible one edge after the strobe and reads one edge after theirs, so every read in the bench is taken at the falling edge that follows its strobe.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_COUNT = 32;
  localparam int HALF_W    = 16;
  localparam int ADDR_W    = 6;

  localparam logic [ADDR_W-1:0] A_STAT_LO = 6'h08;
  localparam logic [ADDR_W-1:0] A_STAT_HI = 6'h0A;
  localparam logic [ADDR_W-1:0] A_EN_LO   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_EN_HI   = 6'h0E;
  localparam logic [ADDR_W-1:0] A_KIND_LO = 6'h10;
  localparam logic [ADDR_W-1:0] A_KIND_HI = 6'h12;
  localparam logic [ADDR_W-1:0] A_POL_LO  = 6'h14;
  localparam logic [ADDR_W-1:0] A_POL_HI  = 6'h16;
  localparam logic [ADDR_W-1:0] A_LAT_LO  = 6'h18;
  localparam logic [ADDR_W-1:0] A_LAT_HI  = 6'h1A;
  localparam logic [ADDR_W-1:0] A_FALL_LO = 6'h20;
  localparam logic [ADDR_W-1:0] A_FALL_HI = 6'h22;
  localparam logic [ADDR_W-1:0] A_RISE_LO = 6'h24;
  localparam logic [ADDR_W-1:0] A_RISE_HI = 6'h26;

  typedef struct packed {
    logic [PIN_COUNT-1:0] en;
    logic [PIN_COUNT-1:0] edge_kind;
    logic [PIN_COUNT-1:0] act_high;
    logic [PIN_COUNT-1:0] latch;
    logic [PIN_COUNT-1:0] fall_sel;
    logic [PIN_COUNT-1:0] rise_sel;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [HALF_W-1:0]    wdata_i,
  input  logic [PIN_COUNT-1:0] status_i,
  output pin_cfg_t             cfg_o,
  output logic [PIN_COUNT-1:0] clr_o,
  output logic [HALF_W-1:0]    rdata_o
);
  localparam int HI = PIN_COUNT - 1;
  localparam int LO_TOP = HALF_W - 1;

  pin_cfg_t cfg_q;
  logic [HALF_W-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_EN_LO:   cfg_q.en[LO_TOP:0]          <= wdata_i;
        A_EN_HI:   cfg_q.en[HI:HALF_W]         <= wdata_i;
        A_KIND_LO: cfg_q.edge_kind[LO_TOP:0]   <= wdata_i;
        A_KIND_HI: cfg_q.edge_kind[HI:HALF_W]  <= wdata_i;
        A_POL_LO:  cfg_q.act_high[LO_TOP:0]    <= wdata_i;
        A_POL_HI:  cfg_q.act_high[HI:HALF_W]   <= wdata_i;
        A_LAT_LO:  cfg_q.latch[LO_TOP:0]       <= wdata_i;
        A_LAT_HI:  cfg_q.latch[HI:HALF_W]      <= wdata_i;
        A_FALL_LO: cfg_q.fall_sel[LO_TOP:0]    <= wdata_i;
        A_FALL_HI: cfg_q.fall_sel[HI:HALF_W]   <= wdata_i;
        A_RISE_LO: cfg_q.rise_sel[LO_TOP:0]    <= wdata_i;
        A_RISE_HI: cfg_q.rise_sel[HI:HALF_W]   <= wdata_i;
        default: ;
      endcase
    end
  end

  // status clear is a write-one pulse, not a stored register
  always_comb begin
    clr_o = '0;
    if (wr_en_i && addr_i == A_STAT_LO) clr_o[LO_TOP:0]  = wdata_i;
    if (wr_en_i && addr_i == A_STAT_HI) clr_o[HI:HALF_W] = wdata_i;
  end

  always_comb begin
    case (addr_i)
      A_STAT_LO: rd_mux = status_i[LO_TOP:0];
      A_STAT_HI: rd_mux = status_i[HI:HALF_W];
      A_EN_LO:   rd_mux = cfg_q.en[LO_TOP:0];
      A_EN_HI:   rd_mux = cfg_q.en[HI:HALF_W];
      A_KIND_LO: rd_mux = cfg_q.edge_kind[LO_TOP:0];
      A_KIND_HI: rd_mux = cfg_q.edge_kind[HI:HALF_W];
      A_POL_LO:  rd_mux = cfg_q.act_high[LO_TOP:0];
      A_POL_HI:  rd_mux = cfg_q.act_high[HI:HALF_W];
      A_LAT_LO:  rd_mux = cfg_q.latch[LO_TOP:0];
      A_LAT_HI:  rd_mux = cfg_q.latch[HI:HALF_W];
      A_FALL_LO: rd_mux = cfg_q.fall_sel[LO_TOP:0];
      A_FALL_HI: rd_mux = cfg_q.fall_sel[HI:HALF_W];
      A_RISE_LO: rd_mux = cfg_q.rise_sel[LO_TOP:0];
      A_RISE_HI: rd_mux = cfg_q.rise_sel[HI:HALF_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign cfg_o = cfg_q;

  assert_en_lo_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EN_LO) |=> (cfg_o.en[LO_TOP:0] == $past(wdata_i)));
  assert_rise_hi_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_RISE_HI) |=> (cfg_o.rise_sel[HI:HALF_W] == $past(wdata_i)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_COUNT-1:0] sync_i,
  input  pin_cfg_t             cfg_i,
  input  logic [PIN_COUNT-1:0] clr_i,
  output logic [PIN_COUNT-1:0] status_o
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    logic prev_q, st_q, lvl, rise, fall, det, st_d;

    always_comb begin
      rise = sync_i[i] & ~prev_q;
      fall = ~sync_i[i] & prev_q;
      lvl  = cfg_i.act_high[i] ? sync_i[i] : ~sync_i[i];
      det  = cfg_i.edge_kind[i] ? ((cfg_i.rise_sel[i] & rise) | (cfg_i.fall_sel[i] & fall))
                                : lvl;
      // latched: new events win over a same-cycle clear
      st_d = cfg_i.latch[i] ? ((st_q & ~clr_i[i]) | det) : det;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        st_q   <= 1'b0;
      end else begin
        prev_q <= sync_i[i];
        st_q   <= st_d;
      end
    end

    assign status_o[i] = st_q;

    assert_latch_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i.latch[i] && st_q && !clr_i[i]) |=> st_q);
    assert_clear_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i.latch[i] && clr_i[i] && cfg_i.edge_kind[i] && !cfg_i.rise_sel[i]
       && !cfg_i.fall_sel[i]) |=> !st_q);
    assert_no_edge_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i.edge_kind[i] && !cfg_i.latch[i] && !cfg_i.rise_sel[i] && !cfg_i.fall_sel[i])
      |=> !st_q);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_COUNT-1:0] pins_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [HALF_W-1:0]    wdata_i,
  output logic [HALF_W-1:0]    rdata_o,
  output logic                 irq_o
);
  logic [PIN_COUNT-1:0] sync_pins, status, clr;
  pin_cfg_t cfg;

  gpio_irq_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(sync_pins));

  gpio_irq_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .status_i(status),
    .cfg_o(cfg), .clr_o(clr), .rdata_o(rdata_o));

  gpio_irq_detect u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_pins), .cfg_i(cfg),
    .clr_i(clr), .status_o(status));

  assign irq_o = |(status & cfg.en);

  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.en == '0) |-> !irq_o);
  assert_pending_raises_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[0] && cfg.en[0]) |-> irq_o);
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl u0 (.clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", {31'b0, irq}, 0);
    rd(6'h0C, v); check("R1 enable lo", {16'b0, v}, 0);
    rd(6'h12, v); check("R1 kind hi", {16'b0, v}, 0);
    rd(6'h26, v); check("R1 rise hi", {16'b0, v}, 0);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    wr(6'h0E, 16'hA5A5); rd(6'h0E, v); check("R2 enable hi", {16'b0, v}, 32'hA5A5);
    wr(6'h20, 16'h1234); rd(6'h20, v); check("R2 fall lo", {16'b0, v}, 32'h1234);
    wr(6'h18, 16'h00F0); rd(6'h18, v); check("R2 latch lo", {16'b0, v}, 32'h00F0);
    rd(6'h04, v); check("R2 unmapped", {16'b0, v}, 0);
    wr(6'h0E, 0); wr(6'h20, 0); wr(6'h18, 0);
  endtask

  task automatic t_level();
    logic [15:0] v;
    wr(6'h14, 16'hFFFF); wr(6'h16, 16'hFFFF);
    tick(3);
    rd(6'h08, v); check("R3 idle low", {16'b0, v}, 0);
    pins[3] = 1'b1; tick(3);
    rd(6'h08, v); check("R3 follows high", {31'b0, v[3]}, 1);
    pins[3] = 1'b0; tick(3);
    rd(6'h08, v); check("R3 follows low", {31'b0, v[3]}, 0);
  endtask

  task automatic t_polarity();
    logic [15:0] v;
    wr(6'h14, 16'hFFDF); tick(3);
    rd(6'h08, v); check("R4 active low idle", {31'b0, v[5]}, 1);
    pins[5] = 1'b1; tick(3);
    rd(6'h08, v); check("R4 active low driven", {31'b0, v[5]}, 0);
    wr(6'h14, 16'hFFFF); pins[5] = 1'b0; tick(3);
  endtask

  task automatic t_mask();
    pins[3] = 1'b1; tick(3);
    check("R8 masked", {31'b0, irq}, 0);
    wr(6'h0C, 16'h0008);
    check("R8 enable raises", {31'b0, irq}, 1);
    pins[3] = 1'b0; tick(2);
    check("R3 latency old value", {31'b0, irq}, 1);
    tick(1);
    check("R3 latency new value", {31'b0, irq}, 0);
    wr(6'h0C, 0);
  endtask

  task automatic t_rise_latch();
    logic [15:0] v;
    wr(6'h12, 16'h0010); wr(6'h1A, 16'h0010); wr(6'h26, 16'h0010);
    pins[20] = 1'b1; tick(3); pins[20] = 1'b0; tick(3);
    rd(6'h0A, v); check("R7 held after pulse", {31'b0, v[4]}, 1);
    wr(6'h0A, 16'h0000);
    rd(6'h0A, v); check("R6 zero write keeps", {31'b0, v[4]}, 1);
    wr(6'h0A, 16'h0010);
    rd(6'h0A, v); check("R6 one write clears", {31'b0, v[4]}, 0);
  endtask

  task automatic t_fall();
    logic [15:0] v;
    wr(6'h12, 16'h0030); wr(6'h1A, 16'h0030); wr(6'h22, 16'h0020);
    pins[21] = 1'b1; tick(3);
    rd(6'h0A, v); check("R5 fall ignores rise", {31'b0, v[5]}, 0);
    pins[21] = 1'b0; tick(3);
    rd(6'h0A, v); check("R5 fall detected", {31'b0, v[5]}, 1);
    wr(6'h0A, 16'h0020);
  endtask

  task automatic t_both();
    logic [15:0] v;
    wr(6'h12, 16'h0070); wr(6'h1A, 16'h0070);
    wr(6'h22, 16'h0060); wr(6'h26, 16'h0050);
    pins[22] = 1'b1; tick(3);
    rd(6'h0A, v); check("R5 both rise", {31'b0, v[6]}, 1);
    wr(6'h0A, 16'h0040);
    rd(6'h0A, v); check("R6 cleared", {31'b0, v[6]}, 0);
    pins[22] = 1'b0; tick(3);
    rd(6'h0A, v); check("R5 both fall", {31'b0, v[6]}, 1);
  endtask

  task automatic t_pulse();
    wr(6'h10, 16'h0100); wr(6'h24, 16'h0100); wr(6'h0C, 16'h0100);
    pins[8] = 1'b1; tick(2);
    check("R5 pulse not yet", {31'b0, irq}, 0);
    tick(1);
    check("R5 pulse high", {31'b0, irq}, 1);
    tick(1);
    check("R5 pulse one cycle", {31'b0, irq}, 0);
  endtask

  initial begin
    tick(2); rst_n = 1'b1; tick(1);
    t_reset();
    t_readback();
    t_level();
    t_polarity();
    t_mask();
    t_rise_latch();
    t_fall();
    t_both();
    t_pulse();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule